// File: doc/BRIEF.md
# Write Start-Address Sequencer

This block produces the start address of every write burst in a programmed run. A run begins with a `start` pulse. The block takes the window limits, a first-address offset and an increment or seed value from its configuration pins. It then presents one address at a time on a valid/ready output. Each accepted address moves the sequence on to the next one.

There are five step rules. In stride mode a fixed programmed increment is added. In automatic mode the step comes from the burst size, length and type. Three random modes draw addresses from an internal 64-bit LFSR and fold them into the window. In every mode, an address that would pass the high limit is replaced by the base address.

Output rules for back-pressure:
- The address is offered while `out_valid` is high.
- A transfer happens on a rising clock edge when `out_valid` and `out_ready` are both high.
- While `out_ready` is low, the offered address is held unchanged.
- After `start`, `out_valid` stays high, because the sequence never runs out.

Top module: `agen_start_addr`

## Requirements
- R1: During and after reset, `out_valid` is 0 and `out_addr` is 0 until the first `start`.
- R2: In the non-random modes, `start` makes the first address (base + offset) visible on the following cycle, with `out_valid` at 1. This first address is folded by R7.
- R3: While `out_valid` is 1 and `out_ready` is 0, `out_addr` does not change.
- R4: In mode 0 (stride), each accepted address is followed by the previous address plus `incr`.
- R5: In mode 1 (automatic) with burst 1 (INCR) or 2 (WRAP), the step is (2^size)*(len+1).
- R6: In mode 1 with burst 0 (FIXED), the step is 2^size, and `len` has no effect.
- R7: A candidate address greater than `high` is replaced by `base`, and so is a sum that carries out of 64 bits. A candidate equal to `high` is kept.
- R8: In modes 2, 3 and 4 (random), `start` loads `incr` as the seed, and a zero seed becomes 1. The generator shifts left, and its new bit 0 is s[63]^s[62]^s[60]^s[59]. The k-th address of the run is taken from the state after k shifts.
- R9: A random value r is mapped into the window as follows:
  - m is the smallest all-ones mask that covers high-base.
  - v = r & m; if v > high-base, then v = v - (high-base+1).
  - The address is base + v. It always lies in [base, high].
- R10: In mode 3 (aligned random), the low `size` bits of the mapped address are cleared.
- R11: In mode 4 (unaligned random), an even mapped address is made odd by setting bit 0. If the address equals `high`, it is made odd by subtracting 1 instead.
- R12: A `start` in the same cycle as an accepted transfer wins. The next address is the first address of the new run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a new run from the current configuration |
| mode | input | 3 | Step rule: 0 stride, 1 automatic, 2 random, 3 random aligned, 4 random unaligned |
| burst | input | 2 | Burst type: 0 FIXED, 1 INCR, 2 WRAP |
| len | input | 8 | Burst length minus one |
| size | input | 3 | log2 of the bytes per beat |
| base | input | 64 | Lowest address of the window |
| high | input | 64 | Highest address of the window |
| offset | input | 64 | Offset added to base for the first address |
| incr | input | 64 | Stride in mode 0; seed in the random modes |
| out_valid | output | 1 | An address is offered |
| out_ready | input | 1 | The consumer takes the offered address |
| out_addr | output | 64 | Offered start address |

## Verification
The assertions assume that the configuration pins change only together with `start` and stay steady for the rest of the run. They also assume:
- `base` is not above `high`;
- in aligned mode, `base` is a multiple of the beat size;
- in unaligned mode, the window holds at least two bytes;
- `size` never exceeds the bus maximum.

The stimulus changes every configuration field in the same step as the `start` pulse and chooses every window to meet these conditions. The window checks therefore hold in each run, including the runs that fold at the top of the 64-bit space.

// File: rtl/agen_pkg.sv
package agen_pkg;
  localparam int LFSR_W = 64;
  localparam logic [LFSR_W-1:0] LFSR_ZERO_SUB = 64'h1;

  typedef enum logic [2:0] {
    AM_STRIDE      = 3'd0,
    AM_AUTO        = 3'd1,
    AM_RND_ANY     = 3'd2,
    AM_RND_ALIGN   = 3'd3,
    AM_RND_UNALIGN = 3'd4
  } agen_mode_e;

  localparam logic [1:0] BT_FIXED = 2'd0;

  function automatic logic [LFSR_W-1:0] lfsr_shift(input logic [LFSR_W-1:0] s);
    return {s[62:0], s[63] ^ s[62] ^ s[60] ^ s[59]};
  endfunction

  function automatic logic mode_is_random(input logic [2:0] m);
    return (m == AM_RND_ANY) || (m == AM_RND_ALIGN) || (m == AM_RND_UNALIGN);
  endfunction
endpackage

// File: rtl/agen_lfsr.sv
module agen_lfsr
  import agen_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              adv,
  input  logic [LFSR_W-1:0] seed,
  output logic [LFSR_W-1:0] peek
);
  logic [LFSR_W-1:0] state_q;
  logic [LFSR_W-1:0] seed_nz;
  logic [LFSR_W-1:0] seed_step;
  logic [LFSR_W-1:0] cur_step;

  assign seed_nz   = (seed == '0) ? LFSR_ZERO_SUB : seed;
  assign seed_step = lfsr_shift(seed_nz);
  assign cur_step  = lfsr_shift(state_q);
  assign peek      = load ? seed_step : cur_step;

  always_ff @(posedge clk) begin
    if (!rst_n)      state_q <= LFSR_ZERO_SUB;
    else if (load)   state_q <= seed_step;
    else if (adv)    state_q <= cur_step;
  end

  // R8: a loaded generator never sits in the all-zero lock-up state
  p_lfsr_live_r8: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> state_q != '0);
endmodule

// File: rtl/agen_step.sv
module agen_step
  import agen_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int LEN_W  = 8,
  parameter int SIZE_W = 3
) (
  input  logic [2:0]        mode,
  input  logic [1:0]        burst,
  input  logic [LEN_W-1:0]  len,
  input  logic [SIZE_W-1:0] size,
  input  logic [ADDR_W-1:0] incr,
  output logic [ADDR_W-1:0] step
);
  logic [ADDR_W-1:0] beats;

  always_comb begin
    beats = (burst == BT_FIXED) ? ADDR_W'(1) : (ADDR_W'(len) + ADDR_W'(1));
    if (mode == AM_AUTO) step = beats << size;
    else                 step = incr;
  end
endmodule

// File: rtl/agen_window_map.sv
module agen_window_map
  import agen_pkg::*;
#(
  parameter int ADDR_W   = 64,
  parameter int SIZE_W   = 3,
  parameter int MAX_SIZE = 6
) (
  input  logic [ADDR_W-1:0] raw,
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W-1:0] high,
  input  logic [SIZE_W-1:0] size,
  input  logic [2:0]        mode,
  output logic [ADDR_W-1:0] addr
);
  localparam int SMEAR_N = $clog2(ADDR_W);

  logic [ADDR_W-1:0] span;
  logic [ADDR_W-1:0] mask;
  logic [ADDR_W-1:0] v;
  logic [ADDR_W-1:0] folded;
  logic [ADDR_W-1:0] aligned;
  logic [ADDR_W-1:0] odd;

  always_comb begin
    span = high - base;
    mask = span;
    for (int i = 0; i < SMEAR_N; i++) mask = mask | (mask >> (1 << i));
    v = raw & mask;
    if (v > span) v = v - span - ADDR_W'(1);
    folded  = base + v;
    aligned = folded & ~((ADDR_W'(1) << size) - ADDR_W'(1));
  end

  generate
    if (MAX_SIZE > 0) begin : g_odd
      always_comb begin
        if (folded[0])          odd = folded;
        else if (folded == high) odd = folded - ADDR_W'(1);
        else                    odd = folded | ADDR_W'(1);
      end
    end else begin : g_no_odd
      assign odd = folded;
    end
  endgenerate

  always_comb begin
    case (mode)
      AM_RND_ALIGN:   addr = aligned;
      AM_RND_UNALIGN: addr = odd;
      default:        addr = folded;
    endcase
  end
endmodule

// File: rtl/agen_start_addr.sv
module agen_start_addr
  import agen_pkg::*;
#(
  parameter int ADDR_W   = 64,
  parameter int LEN_W    = 8,
  parameter int SIZE_W   = 3,
  parameter int MAX_SIZE = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [2:0]        mode,
  input  logic [1:0]        burst,
  input  logic [LEN_W-1:0]  len,
  input  logic [SIZE_W-1:0] size,
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W-1:0] high,
  input  logic [ADDR_W-1:0] offset,
  input  logic [ADDR_W-1:0] incr,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [ADDR_W-1:0] out_addr
);
  logic [ADDR_W-1:0] addr_q;
  logic              vld_q;
  logic              accept;
  logic              rnd;
  logic [ADDR_W-1:0] step_w;
  logic [LFSR_W-1:0] lfsr_peek;
  logic [ADDR_W-1:0] rnd_addr;
  logic [ADDR_W:0]   first_sum;
  logic [ADDR_W:0]   next_sum;
  logic [ADDR_W-1:0] first_addr;
  logic [ADDR_W-1:0] next_addr;

  assign accept = vld_q && out_ready;
  assign rnd    = mode_is_random(mode);

  agen_step #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .SIZE_W(SIZE_W)) u_step (
    .mode(mode), .burst(burst), .len(len), .size(size), .incr(incr), .step(step_w)
  );

  agen_lfsr u_lfsr (
    .clk(clk), .rst_n(rst_n),
    .load(start && rnd), .adv(accept && rnd && !start),
    .seed(LFSR_W'(incr)), .peek(lfsr_peek)
  );

  agen_window_map #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .MAX_SIZE(MAX_SIZE)) u_map (
    .raw(ADDR_W'(lfsr_peek)), .base(base), .high(high), .size(size),
    .mode(mode), .addr(rnd_addr)
  );

  always_comb begin
    first_sum  = {1'b0, base} + {1'b0, offset};
    next_sum   = {1'b0, addr_q} + {1'b0, step_w};
    first_addr = (first_sum > {1'b0, high}) ? base : first_sum[ADDR_W-1:0];
    next_addr  = (next_sum  > {1'b0, high}) ? base : next_sum[ADDR_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      addr_q <= '0;
    end else if (start) begin
      vld_q  <= 1'b1;
      addr_q <= rnd ? rnd_addr : first_addr;
    end else if (accept) begin
      addr_q <= rnd ? rnd_addr : next_addr;
    end
  end

  assign out_valid = vld_q;
  assign out_addr  = addr_q;

  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n || start)
    out_valid && !out_ready |=> $stable(out_addr) && out_valid);

  p_stride_step_r4: assert property (@(posedge clk) disable iff (!rst_n || start)
    accept && mode == AM_STRIDE |=> out_addr == $past(base) || out_addr == $past(addr_q) + $past(incr));

  p_auto_step_r5: assert property (@(posedge clk) disable iff (!rst_n || start)
    accept && mode == AM_AUTO |=> out_addr == $past(base) || out_addr == $past(addr_q) + $past(step_w));

  p_window_r9: assert property (@(posedge clk) disable iff (!rst_n || start)
    out_valid |-> out_addr >= base && out_addr <= high);

  p_aligned_r10: assert property (@(posedge clk) disable iff (!rst_n || start)
    out_valid && mode == AM_RND_ALIGN |-> (out_addr & ((ADDR_W'(1) << size) - ADDR_W'(1))) == '0);

  p_odd_r11: assert property (@(posedge clk) disable iff (!rst_n || start)
    out_valid && mode == AM_RND_UNALIGN |-> out_addr[0]);
endmodule

// File: tb/agen_start_addr_tb.sv
module agen_start_addr_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  mode = '0;
  logic [1:0]  burst = '0;
  logic [7:0]  len = '0;
  logic [2:0]  size = '0;
  logic [63:0] base = '0, high = '0, offset = '0, incr = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [63:0] out_addr;

  typedef struct { logic [63:0] a; string tag; } exp_t;
  exp_t q[$];
  int checks = 0;
  int fails = 0;

  always #10 clk = ~clk;

  agen_start_addr u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .burst(burst),
    .len(len), .size(size), .base(base), .high(high), .offset(offset),
    .incr(incr), .out_valid(out_valid), .out_ready(out_ready), .out_addr(out_addr)
  );

  task automatic check(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] m_shift(input logic [63:0] s);
    return {s[62:0], s[63] ^ s[62] ^ s[60] ^ s[59]};
  endfunction

  function automatic logic [63:0] m_fold(input logic [64:0] c);
    return (c > {1'b0, high}) ? base : c[63:0];
  endfunction

  function automatic logic [63:0] m_map(input logic [63:0] r);
    logic [63:0] span, m, v, a;
    span = high - base;
    m = 0;
    for (int b = 0; b < 64; b++) if (span >> b != 0) m[b] = 1'b1;
    v = r & m;
    if (v > span) v = v - (span + 64'd1);
    a = base + v;
    if (mode == 3) a = (a >> size) << size;
    if (mode == 4 && !a[0]) a = (a == high) ? a - 64'd1 : a | 64'd1;
    return a;
  endfunction

  function automatic logic [63:0] m_step();
    if (mode == 0) return incr;
    if (burst == 0) return 64'd1 << size;
    return (64'(len) + 64'd1) << size;
  endfunction

  task automatic push_run(input string tag, input int n);
    logic [63:0] s, a;
    if (mode >= 2) begin
      s = (incr == 0) ? 64'd1 : incr;
      for (int k = 0; k < n; k++) begin
        s = m_shift(s);
        q.push_back('{m_map(s), tag});
      end
    end else begin
      a = m_fold({1'b0, base} + {1'b0, offset});
      q.push_back('{a, (tag == "") ? "R2" : tag});
      for (int k = 1; k < n; k++) begin
        a = m_fold({1'b0, a} + {1'b0, m_step()});
        q.push_back('{a, tag});
      end
    end
  endtask

  task automatic cfg(input logic [2:0] md, input logic [1:0] bt, input logic [7:0] ln,
                     input logic [2:0] sz, input logic [63:0] b, input logic [63:0] h,
                     input logic [63:0] o, input logic [63:0] inc);
    mode = md; burst = bt; len = ln; size = sz; base = b; high = h; offset = o; incr = inc;
  endtask

  task automatic drain();
    while (q.size() > 0) begin
      out_ready = ($urandom % 4) != 0;
      @(posedge clk); #1;
    end
    out_ready = 1'b0;
  endtask

  task automatic run(input string tag, input int n, input int stall);
    out_ready = 1'b0;
    q.delete();
    push_run(tag, n);
    start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    for (int i = 0; i < stall; i++) begin
      @(negedge clk);
      check(out_valid && out_addr == q[0].a, "R3", out_addr, q[0].a);
    end
    @(posedge clk); #1;
    drain();
  endtask

  always @(negedge clk) begin
    if (rst_n && !start && out_valid && q.size() > 0) begin
      check(out_addr == q[0].a, q[0].tag, out_addr, q[0].a);
      if (out_ready) void'(q.pop_front());
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(out_valid == 1'b0 && out_addr == 64'd0, "R1", out_addr, 64'd0);
    @(posedge clk); #1;
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0 && out_addr == 64'd0, "R1", out_addr, 64'd0);
    @(posedge clk); #1;

    // R4 stride with a held first address (R3)
    cfg(0, 1, 0, 4, 64'h0, 64'hF_FFFF, 64'h1, 64'h41);
    run("R4", 8, 4);
    // R5 automatic INCR and WRAP
    cfg(1, 1, 0, 6, 64'h0, 64'hFFFF_FFFF, 64'h0, 64'h0);
    run("R5", 6, 0);
    cfg(1, 2, 1, 3, 64'h100, 64'hFFFF, 64'h8, 64'h0);
    run("R5", 6, 0);
    cfg(1, 1, 3, 2, 64'h0, 64'hFFFF, 64'h0, 64'h0);
    run("R5", 6, 0);
    // R6 automatic FIXED: len has no effect
    cfg(1, 0, 4, 5, 64'h0, 64'hFFFF_FFFF, 64'h0, 64'h0);
    run("R6", 6, 0);
    cfg(1, 0, 8'hFF, 5, 64'h0, 64'hFFFF_FFFF, 64'h0, 64'h0);
    run("R6", 6, 0);
    // R7 folding: equal to high kept, beyond high wraps, carry out wraps
    cfg(0, 1, 0, 0, 64'h1000, 64'h1030, 64'h0, 64'h10);
    run("R7", 10, 0);
    cfg(0, 1, 0, 0, 64'h1000, 64'h1030, 64'h0, 64'h20);
    run("R7", 6, 0);
    cfg(0, 1, 0, 0, 64'hFFFF_FFFF_FFFF_FF00, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 64'h80);
    run("R7", 6, 0);
    cfg(0, 1, 0, 0, 64'h100, 64'h1FF, 64'h300, 64'h4);
    run("R7", 3, 0);
    // R8 / R9 random in window, seeded and zero seed
    cfg(2, 1, 0, 0, 64'h1000, 64'h1FFF, 64'h0, 64'h1234);
    run("R9", 24, 0);
    cfg(2, 1, 0, 0, 64'h5000, 64'h5ABC, 64'h0, 64'h0);
    run("R8", 24, 0);
    // R10 aligned random
    cfg(3, 1, 0, 4, 64'h2000, 64'h2ABC, 64'h0, 64'hBEEF);
    run("R10", 24, 0);
    // R11 unaligned random, small window to hit the top edge
    cfg(4, 1, 0, 2, 64'h3000, 64'h3006, 64'h0, 64'h77);
    run("R11", 32, 0);

    // R12 restart in the same cycle as an accept
    cfg(0, 1, 0, 0, 64'h0, 64'hFFFF, 64'h0, 64'h8);
    q.delete();
    push_run("R4", 20);
    start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    out_ready = 1'b1;
    repeat (3) begin @(posedge clk); #1; end
    q.delete();
    cfg(0, 1, 0, 0, 64'h400, 64'hFFFF, 64'h4, 64'h10);
    push_run("R12", 5);
    start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    drain();

    repeat (2) @(posedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule